// File: doc/BRIEF.md
# Prioritised Fifteen-Source Interrupt Controller

This block collects fifteen interrupt sources, numbered 1 to 15, into a pending register. A second register masks them. The block then reports the highest-numbered request that is both pending and unmasked to the processor. It reports it in two forms: a 4-bit interrupt level, and an 8-bit trap type equal to the level plus 0x10. Source n uses bit n in every per-source register, and that same value is its priority, so source 15 wins over all the others. Bit 0 is reserved.

Software uses a small 32-bit register bus with five registers. Pending is read-only and returns the raw latched bits. Mask is read/write. Clear is write-only: writing a 1 to a bit removes that pending bit. Force is write-only: writing a 1 to a bit sets that pending bit. Test control holds a single enable bit, and force writes only take effect while that bit is set. Sources arrive as single-cycle pulses. When the processor takes an interrupt, it returns the taken level on an acknowledge input, and the controller clears that pending bit.

Top module: `prio_intc`

## Requirements
- R1: After reset, the pending register reads 0x00000000 and the mask register reads 0x0000FFFE, so every source is masked. The level output is 0 and the trap output is 0x00.
- R2: A one-cycle pulse on source input bit n (n = 1..15) sets pending bit n, and the bit is visible in the cycle after the pulse. Source input bit 0 is ignored, and pending bit 0 always reads 0.
- R3: A bus read at offset 0x48 returns the latched pending bits whatever the mask holds.
- R4: A bus write at offset 0x4C loads the mask with bits 15:1 of the write data. Bit 0 reads back as 0. A 1 in mask bit n keeps source n out of the level output.
- R5: The level output equals the highest index n for which pending bit n is 1 and mask bit n is 0. When no such bit exists, the level output is 0.
- R6: The trap output equals 0x10 + level when the level is nonzero, and 0x00 when the level is 0.
- R7: A bus write at offset 0x50 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R8: If a source pulse and a clear write (or an acknowledge) hit the same bit in the same cycle, the bit stays pending.
- R9: A bus write at offset 0x54 sets every pending bit whose write-data bit is 1, but only while test-control bit 19 is 1. While that bit is 0, force writes leave the pending register unchanged.
- R10: The test-control register at offset 0xD0 stores only bit 19 of the write data. A read returns 0x00080000 when the bit is set and 0 otherwise.
- R11: An acknowledge with a nonzero level L clears pending bit L in the next cycle. An acknowledge with level 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_evt | input | 16 | Source pulses; bit n is source n, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ack_valid | input | 1 | Processor has taken an interrupt |
| ack_level | input | 4 | Level that was taken |
| irq_level | output | 4 | Highest unmasked pending source, 0 if none |
| irq_trap | output | 8 | Trap type for irq_level, 0 if none |

## Verification
A stuck or lost pending bit shows up directly at the ports. A read of offset 0x48 returns the wrong bits, and the level output moves in the cycle after the faulty edge. This lets the bench compare both views at the first negative edge after each stimulus. A priority or mask fault does not show up on the pending read. It appears only as a wrong level and trap, and only for patterns where the highest unmasked bit differs from the highest raw bit. For this reason the sweep pairs many pending patterns with many mask patterns. Gating faults in force, clear or acknowledge leave a pending read that differs from the arithmetic model one cycle after the access.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC      = 15;
  localparam int LVL_W     = $clog2(NSRC + 1);
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int TRAP_W    = 8;
  localparam int TEST_BIT  = 19;
  localparam logic [TRAP_W-1:0] TRAP_BASE = 8'h10;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_FRC   = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 8'hD0;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC:0]     pend_q,
  output logic [NSRC:0]     mask_q,
  output logic              test_en,
  output logic [NSRC:0]     clr_bits,
  output logic [NSRC:0]     frc_bits,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [NSRC:0] SRC_BITS = {{NSRC{1'b1}}, 1'b0};

  logic          wr_mask, wr_clr, wr_frc, wr_test;
  logic [NSRC:0] mask_d;
  logic          test_d;
  logic          mask_en, test_en_ld;

  always_comb begin
    wr_mask = sel && wr && (addr == OFS_MASK);
    wr_clr  = sel && wr && (addr == OFS_CLR);
    wr_frc  = sel && wr && (addr == OFS_FRC);
    wr_test = sel && wr && (addr == OFS_TEST);
  end

  always_comb begin
    mask_en    = wr_mask;
    mask_d     = wdata[NSRC:0] & SRC_BITS;
    test_en_ld = wr_test;
    test_d     = wdata[TEST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= SRC_BITS;
      test_en <= 1'b0;
    end else begin
      if (mask_en)    mask_q  <= mask_d;
      if (test_en_ld) test_en <= test_d;
    end
  end

  always_comb begin
    clr_bits = wr_clr ? (wdata[NSRC:0] & SRC_BITS) : '0;
    frc_bits = (wr_frc && test_en) ? (wdata[NSRC:0] & SRC_BITS) : '0;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_PEND: rdata[NSRC:0]   = pend_q;
      OFS_MASK: rdata[NSRC:0]   = mask_q;
      OFS_TEST: rdata[TEST_BIT] = test_en;
      default:  rdata = '0;
    endcase
  end

  AST_FRC_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_bits != '0) |-> test_en); // R9
  AST_MASK_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q[0] == 1'b0)); // R4
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC:0]    src,
  input  logic [NSRC:0]    clr_bits,
  input  logic [NSRC:0]    frc_bits,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [NSRC:0]    pend_q
);
  localparam logic [NSRC:0] SRC_BITS = {{NSRC{1'b1}}, 1'b0};

  logic [NSRC:0] ack_oh;
  logic [NSRC:0] pend_d;

  always_comb begin
    ack_oh = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (ack_valid && (ack_level == LVL_W'(i))) ack_oh[i] = 1'b1;
    end
  end

  always_comb begin
    pend_d = ((pend_q & ~clr_bits & ~ack_oh) | src | frc_bits) & SRC_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != '0 && !src[ack_level] && !frc_bits[ack_level])
      |=> !pend_q[$past(ack_level)]); // R11
  AST_SRC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(src & SRC_BITS)) == $past(src & SRC_BITS))); // R8
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [NSRC:0]     pend_q,
  input  logic [NSRC:0]     mask_q,
  output logic [LVL_W-1:0]  level,
  output logic [TRAP_W-1:0] trap
);
  logic [NSRC:0] active;

  always_comb begin
    active = pend_q & ~mask_q;
    level  = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (active[i]) level = LVL_W'(i);
    end
    trap = (level != '0) ? (TRAP_BASE + TRAP_W'(level)) : '0;
  end

  always_comb begin
    if (level != '0) AST_LEVEL_ACTIVE: assert (active[level]); // R5
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] src_evt,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ack_valid,
  input  logic [3:0]  ack_level,
  output logic [3:0]  irq_level,
  output logic [7:0]  irq_trap
);
  logic [NSRC:0] pend_q, mask_q, clr_bits, frc_bits;
  logic          test_en;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pend_q(pend_q), .mask_q(mask_q), .test_en(test_en),
    .clr_bits(clr_bits), .frc_bits(frc_bits), .rdata(bus_rdata)
  );

  irqc_pending u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_evt), .clr_bits(clr_bits),
    .frc_bits(frc_bits), .ack_valid(ack_valid), .ack_level(ack_level),
    .pend_q(pend_q)
  );

  irqc_prio u_prio (
    .pend_q(pend_q), .mask_q(mask_q), .level(irq_level), .trap(irq_trap)
  );

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_bits == '0) |=>
      ((pend_q & ~$past(pend_q) & ~$past(src_evt)) == '0)); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_bits == '0) |=>
      ((pend_q & $past(clr_bits) & ~$past(src_evt)) == '0)); // R7
  AST_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 4'd0) |-> (irq_trap == 8'h00)); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 4'd0) |-> !mask_q[irq_level]); // R4
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_evt;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_valid;
  logic [3:0]  ack_level;
  logic [3:0]  irq_level;
  logic [7:0]  irq_trap;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .irq_trap(irq_trap)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; src_evt = '0; ack_valid = 0; ack_level = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 0; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [3:0] exp_lvl(input logic [15:0] p, input logic [15:0] m);
    logic [15:0] a = p & ~m & 16'hFFFE;
    exp_lvl = 0;
    for (int i = 1; i < 16; i++) if (a[i]) exp_lvl = 4'(i);
  endfunction

  function automatic logic [7:0] exp_trap(input logic [3:0] l);
    exp_trap = (l == 0) ? 8'h00 : 8'h10 + 8'(l);
  endfunction

  task automatic chk_out(input string tag, input logic [15:0] p, input logic [15:0] m);
    logic [3:0] l = exp_lvl(p, m);
    check({tag, " level"}, 32'(irq_level), 32'(l));
    check({tag, " trap R6"}, 32'(irq_trap), 32'(exp_trap(l)));
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] p, m;
    idle(); bus_addr = '0; bus_wdata = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h48, d); check("R1 pending", d, 32'h0);
    rd(8'h4C, d); check("R1 mask", d, 32'h0000FFFE);
    check("R1 level", 32'(irq_level), 0);
    check("R1 trap", 32'(irq_trap), 0);

    // R2 / R5: each source alone, mask open
    wr(8'h4C, 32'h0);
    for (int n = 1; n < 16; n++) begin
      @(negedge clk); src_evt = 16'(1 << n);
      @(negedge clk); src_evt = '0;
      rd(8'h48, d); check("R2 latch", d, 32'(1 << n));
      chk_out("R5 single", 16'(1 << n), 16'h0);
      wr(8'h50, 32'(1 << n));
      rd(8'h48, d); check("R7 clear", d, 0);
    end
    // R2 bit 0 ignored
    @(negedge clk); src_evt = 16'h0001;
    @(negedge clk); src_evt = '0;
    rd(8'h48, d); check("R2 bit0", d, 0);

    // R10 test control
    wr(8'hD0, 32'hFFFFFFFF);
    rd(8'hD0, d); check("R10 set", d, 32'h00080000);
    wr(8'hD0, 32'h00000000);
    rd(8'hD0, d); check("R10 clr", d, 0);

    // R9 force ignored while test bit is clear
    wr(8'h54, 32'h0000FFFF);
    rd(8'h48, d); check("R9 gated", d, 0);
    check("R9 gated level", 32'(irq_level), 0);

    // R3/R4/R5/R9 sweep over pending and mask patterns
    wr(8'hD0, 32'h00080000);
    for (int i = 0; i < 400; i++) begin
      p = 16'((i * 40503) ^ (i << 5)) & 16'hFFFE;
      m = 16'((i * 945) ^ (i >> 2)) & 16'hFFFE;
      if (i % 16 == 0) m = 16'h0;
      wr(8'h50, 32'hFFFF);
      wr(8'h4C, 32'hFFFF0000 | 32'(m));
      wr(8'h54, 32'(p));
      rd(8'h48, d); check("R3 raw pending", d, 32'(p));
      rd(8'h4C, d); check("R4 mask read", d, 32'(m));
      chk_out("R5 sweep", p, m);
    end

    // R7 partial clear: zero bits untouched
    wr(8'h4C, 32'h0);
    wr(8'h50, 32'hFFFF);
    wr(8'h54, 32'h0000A5A4);
    wr(8'h50, 32'h00008420);
    rd(8'h48, d); check("R7 partial", d, 32'h00002184);
    chk_out("R7 level", 16'h2184, 16'h0);

    // R8 event beats clear in same cycle
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h50; bus_wdata = 32'h00000180;
    src_evt = 16'h0100;
    @(negedge clk); idle();
    rd(8'h48, d); check("R8 event wins", d, 32'h00002104);

    // R11 acknowledge clears taken level
    @(negedge clk); ack_valid = 1; ack_level = 4'd13;
    @(negedge clk); idle();
    rd(8'h48, d); check("R11 ack", d, 32'h00000104);
    chk_out("R11 level", 16'h0104, 16'h0);
    @(negedge clk); ack_valid = 1; ack_level = 4'd0;
    @(negedge clk); idle();
    rd(8'h48, d); check("R11 ack zero", d, 32'h00000104);
    // R8 event beats ack
    @(negedge clk); ack_valid = 1; ack_level = 4'd8; src_evt = 16'h0100;
    @(negedge clk); idle();
    rd(8'h48, d); check("R8 event vs ack", d, 32'h00000104);

    // R4 full mask hides everything
    wr(8'h4C, 32'hFFFF);
    check("R4 all masked", 32'(irq_level), 0);
    rd(8'h48, d); check("R3 masked raw", d, 32'h00000104);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule